// File: doc/BRIEF.md
# Microcoded 32-bit Register Datapath

This block carries out one register transfer per clock under the control of a microinstruction. Each cycle it selects a source register onto the B bus, feeds that bus and the holding register H into an ALU, passes the ALU output through a small shifter, and writes the shifted result into any set of nine 32-bit registers chosen by a multi-hot write mask. The ALU output also sets a negative flag and a zero flag, which are registered so that a sequencer can branch on them in the next cycle.

The nine writable registers are H, OPC, TOS, CPP, LV, SP, PC, MDR and MAR. An 8-bit fetch register, loaded from its own byte input, can be placed on the B bus either sign-extended or zero-extended. MAR, MDR and PC are brought out for a memory interface. Control-store sequencing, instruction decode and memory timing belong to neighbouring blocks.

Top module: `mdp_datapath`

## Requirements
- R1: An asynchronous active-low reset clears all nine registers, the fetch register and both flags to zero.
- R2: The B-bus selector codes are 0000 MDR, 0001 PC, 0100 SP, 0101 LV, 0110 CPP, 0111 TOS and 1000 OPC; the selected register's current value is the ALU B input.
- R3: Code 0010 puts the fetch byte on the B bus with bit 7 copied into bits 31..8, and code 0011 puts it there with bits 31..8 zero.
- R4: B-bus codes 1001 to 1111 drive zero onto the bus.
- R5: The ALU A input is always H. The 6-bit ALU control is {F0,F1,ENA,ENB,INVA,INC}: ENA and ENB gate A and B to zero when clear, INVA inverts the gated A, and F0F1 = 00 gives A AND B, 01 gives A OR B, 10 gives NOT B.
- R6: With F0F1 = 11 the ALU adds the gated A, the gated B and INC, modulo 2^32 (so 111100 is H+B, 110101 is B+1, 111111 is B-H, 110110 is B-1).
- R7: The 2-bit shift control is {SLL8,SRA1}: 00 passes the ALU output, 10 shifts it left by 8 with zero fill, 01 shifts it right arithmetically by 1, and 11 applies the left shift by 8 and then the arithmetic right shift by 1.
- R8: The 9-bit write mask is ordered from bit 8 down to bit 0 as H, OPC, TOS, CPP, LV, SP, PC, MDR, MAR; every register whose bit is set loads the same shifted result on the same rising edge.
- R9: A register whose mask bit is clear keeps its value.
- R10: The N flag takes bit 31 of the unshifted ALU output at every rising edge.
- R11: The Z flag is set at every rising edge when the unshifted ALU output is zero and cleared otherwise.
- R12: When the fetch-load input is high the fetch register takes the byte input at the rising edge; a B-bus read of the fetch register in that same cycle sees the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| c_mask | input | 9 | Multi-hot register write mask (bit 8 H ... bit 0 MAR) |
| b_sel | input | 4 | B-bus source code |
| alu_op | input | 6 | ALU control {F0,F1,ENA,ENB,INVA,INC} |
| shift_op | input | 2 | Shifter control {SLL8,SRA1} |
| fetch_ld | input | 1 | Load the fetch register this edge |
| fetch_byte | input | 8 | Byte loaded into the fetch register |
| mar_o | output | 32 | Current MAR value |
| mdr_o | output | 32 | Current MDR value |
| pc_o | output | 32 | Current PC value |
| n_o | output | 1 | Registered negative flag |
| z_o | output | 1 | Registered zero flag |

## Verification
The hardest case to reach is any check on a register that has no port of its own: H, OPC, TOS, CPP, LV and SP can only be seen by routing them through the B bus (or, for H, through the ALU A input with an unassigned B code that yields zero) into MAR. Arbitrary 32-bit values are likewise built only from the byte-wide fetch path, by repeatedly adding a zero-extended byte to H and shifting left by 8. The flag checks that separate the shifted result from the unshifted one use values such as 1 under SRA1 and 0x80000000 under SLL8, where the written register reads zero while Z stays clear or N is set.

// File: rtl/mdp_pkg.sv
`timescale 1ns/1ps
package mdp_pkg;

    parameter int unsigned DATA_W  = 32;
    parameter int unsigned FETCH_W = 8;
    parameter int unsigned NREG    = 9;
    parameter int unsigned BSEL_W  = 4;
    parameter int unsigned ALU_W   = 6;
    parameter int unsigned SHF_W   = 2;

    // Write-mask bit positions, fixed by the control word layout.
    localparam int unsigned RI_MAR = 0;
    localparam int unsigned RI_MDR = 1;
    localparam int unsigned RI_PC  = 2;
    localparam int unsigned RI_SP  = 3;
    localparam int unsigned RI_LV  = 4;
    localparam int unsigned RI_CPP = 5;
    localparam int unsigned RI_TOS = 6;
    localparam int unsigned RI_OPC = 7;
    localparam int unsigned RI_H   = 8;

    typedef enum logic [BSEL_W-1:0] {
        BS_MDR = 4'd0,
        BS_PC  = 4'd1,
        BS_FSX = 4'd2,
        BS_FZX = 4'd3,
        BS_SP  = 4'd4,
        BS_LV  = 4'd5,
        BS_CPP = 4'd6,
        BS_TOS = 4'd7,
        BS_OPC = 4'd8
    } bsrc_e;

    typedef struct packed {
        logic f0;
        logic f1;
        logic ena;
        logic enb;
        logic inva;
        logic inc;
    } alu_ctl_t;

    typedef struct packed {
        logic sll8;
        logic sra1;
    } shf_ctl_t;

endpackage

// File: rtl/mdp_bsel.sv
`timescale 1ns/1ps
module mdp_bsel
    import mdp_pkg::*;
#(
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned BW   = FETCH_W,
    parameter int unsigned NR   = NREG
) (
    input  logic [NR-1:0][DW-1:0] regs_i,
    input  logic [BW-1:0]         fetch_i,
    input  logic [BSEL_W-1:0]     sel_i,
    output logic [DW-1:0]         bus_o
);

    localparam int unsigned EXT_W = DW - BW;

    logic [DW-1:0] fetch_sx;
    logic [DW-1:0] fetch_zx;

    assign fetch_sx = {{EXT_W{fetch_i[BW-1]}}, fetch_i};
    assign fetch_zx = {{EXT_W{1'b0}}, fetch_i};

    always_comb begin
        case (bsrc_e'(sel_i))
            BS_MDR:  bus_o = regs_i[RI_MDR];
            BS_PC:   bus_o = regs_i[RI_PC];
            BS_FSX:  bus_o = fetch_sx;
            BS_FZX:  bus_o = fetch_zx;
            BS_SP:   bus_o = regs_i[RI_SP];
            BS_LV:   bus_o = regs_i[RI_LV];
            BS_CPP:  bus_o = regs_i[RI_CPP];
            BS_TOS:  bus_o = regs_i[RI_TOS];
            BS_OPC:  bus_o = regs_i[RI_OPC];
            default: bus_o = '0;
        endcase
    end

endmodule

// File: rtl/mdp_alu.sv
`timescale 1ns/1ps
module mdp_alu
    import mdp_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_ctl_t      ctl_i,
    output logic [DW-1:0] y_o
);

    logic [DW-1:0] a_g;
    logic [DW-1:0] b_g;

    always_comb begin
        a_g = ctl_i.ena ? a_i : '0;
        if (ctl_i.inva) begin
            a_g = ~a_g;
        end
        b_g = ctl_i.enb ? b_i : '0;
        case ({ctl_i.f0, ctl_i.f1})
            2'b00:   y_o = a_g & b_g;
            2'b01:   y_o = a_g | b_g;
            2'b10:   y_o = ~b_g;
            default: y_o = a_g + b_g + DW'(ctl_i.inc);
        endcase
    end

endmodule

// File: rtl/mdp_shifter.sv
`timescale 1ns/1ps
module mdp_shifter
    import mdp_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned SHL = FETCH_W
) (
    input  shf_ctl_t      ctl_i,
    input  logic [DW-1:0] x_i,
    output logic [DW-1:0] y_o
);

    logic [DW-1:0] left;

    always_comb begin
        left = ctl_i.sll8 ? (x_i << SHL) : x_i;
        y_o  = ctl_i.sra1 ? {left[DW-1], left[DW-1:1]} : left;
    end

endmodule

// File: rtl/mdp_datapath.sv
`timescale 1ns/1ps
module mdp_datapath
    import mdp_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned BW = FETCH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   c_mask,
    input  logic [BSEL_W-1:0] b_sel,
    input  logic [ALU_W-1:0]  alu_op,
    input  logic [SHF_W-1:0]  shift_op,
    input  logic              fetch_ld,
    input  logic [BW-1:0]     fetch_byte,
    output logic [DW-1:0]     mar_o,
    output logic [DW-1:0]     mdr_o,
    output logic [DW-1:0]     pc_o,
    output logic              n_o,
    output logic              z_o
);

    localparam int unsigned NR = NREG;

    typedef struct packed {
        logic [NR-1:0][DW-1:0] r;
        logic [BW-1:0]         fetch;
        logic                  n;
        logic                  z;
    } state_t;

    state_t        st_d;
    state_t        st_q;
    logic [DW-1:0] b_bus;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] sh_y;

    mdp_bsel #(.DW(DW), .BW(BW), .NR(NR)) bsel_i (
        .regs_i  (st_q.r),
        .fetch_i (st_q.fetch),
        .sel_i   (b_sel),
        .bus_o   (b_bus)
    );

    mdp_alu #(.DW(DW)) alu_i (
        .a_i   (st_q.r[RI_H]),
        .b_i   (b_bus),
        .ctl_i (alu_ctl_t'(alu_op)),
        .y_o   (alu_y)
    );

    mdp_shifter #(.DW(DW), .SHL(BW)) shf_i (
        .ctl_i (shf_ctl_t'(shift_op)),
        .x_i   (alu_y),
        .y_o   (sh_y)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NR; i++) begin
            if (c_mask[i]) begin
                st_d.r[i] = sh_y;
            end
        end
        if (fetch_ld) begin
            st_d.fetch = fetch_byte;
        end
        st_d.n = alu_y[DW-1];
        st_d.z = (alu_y == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mar_o = st_q.r[RI_MAR];
    assign mdr_o = st_q.r[RI_MDR];
    assign pc_o  = st_q.r[RI_PC];
    assign n_o   = st_q.n;
    assign z_o   = st_q.z;

endmodule

// File: rtl/mdp_datapath_chk.sv
`timescale 1ns/1ps
module mdp_datapath_chk
    import mdp_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG-1:0]   c_mask,
    input logic [BSEL_W-1:0] b_sel,
    input logic [SHF_W-1:0]  shift_op,
    input logic [DW-1:0]     b_bus,
    input logic [DW-1:0]     alu_y,
    input logic [DW-1:0]     sh_y,
    input logic [DW-1:0]     mar_o,
    input logic [DW-1:0]     mdr_o,
    input logic [DW-1:0]     pc_o,
    input logic              n_o,
    input logic              z_o
);

    p_unused_bsel_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel > 4'd8) |-> (b_bus == '0));

    p_shift_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_op == 2'b00) |-> (sh_y == alu_y));

    p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_mask[RI_PC] |=> (pc_o == $past(sh_y)));

    p_multi_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mask[RI_MDR] && c_mask[RI_MAR]) |=> (mdr_o == mar_o));

    p_mar_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !c_mask[RI_MAR] |=> $stable(mar_o));

    p_flag_n_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (n_o == $past(alu_y[DW-1])));

    p_flag_z_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (z_o == ($past(alu_y) == '0)));

endmodule

bind mdp_datapath mdp_datapath_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .c_mask   (c_mask),
    .b_sel    (b_sel),
    .shift_op (shift_op),
    .b_bus    (b_bus),
    .alu_y    (alu_y),
    .sh_y     (sh_y),
    .mar_o    (mar_o),
    .mdr_o    (mdr_o),
    .pc_o     (pc_o),
    .n_o      (n_o),
    .z_o      (z_o)
);

// File: tb/mdp_datapath_tb_top.sv
`timescale 1ns/1ps
module mdp_datapath_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  c_mask;
    logic [3:0]  b_sel;
    logic [5:0]  alu_op;
    logic [1:0]  shift_op;
    logic        fetch_ld;
    logic [7:0]  fetch_byte;
    logic [31:0] mar_o, mdr_o, pc_o;
    logic        n_o, z_o;

    always #10 clk = ~clk;

    mdp_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .c_mask(c_mask), .b_sel(b_sel),
        .alu_op(alu_op), .shift_op(shift_op), .fetch_ld(fetch_ld),
        .fetch_byte(fetch_byte), .mar_o(mar_o), .mdr_o(mdr_o),
        .pc_o(pc_o), .n_o(n_o), .z_o(z_o)
    );

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] mdl [0:8];
    logic [7:0]  fb_m;
    logic [31:0] seed = 32'h1234_5678;

    localparam logic [5:0] OP_B   = 6'b010100;
    localparam logic [5:0] OP_A   = 6'b011000;
    localparam logic [5:0] OP_ADD = 6'b111100;
    localparam logic [5:0] OP_NEG1 = 6'b110010;
    localparam logic [5:0] OP_INCB = 6'b110101;
    localparam logic [5:0] OP_ZERO = 6'b010000;

    logic [5:0] ops [0:15] = '{6'b010100, 6'b111100, 6'b110101, 6'b011000,
                               6'b011010, 6'b101100, 6'b111101, 6'b111001,
                               6'b111111, 6'b110110, 6'b111011, 6'b001100,
                               6'b011100, 6'b010000, 6'b110001, 6'b110010};

    function automatic logic [31:0] alu_ref(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            6'b010100: return b;
            6'b111100: return a + b;
            6'b110101: return b + 32'd1;
            6'b011000: return a;
            6'b011010: return ~a;
            6'b101100: return ~b;
            6'b111101: return a + b + 32'd1;
            6'b111001: return a + 32'd1;
            6'b111111: return b - a;
            6'b110110: return b - 32'd1;
            6'b111011: return 32'd0 - a;
            6'b001100: return a & b;
            6'b011100: return a | b;
            6'b010000: return 32'd0;
            6'b110001: return 32'd1;
            default:   return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] shf_ref(input logic [1:0] sh, input logic [31:0] x);
        logic [31:0] t;
        t = sh[1] ? x * 32'd256 : x;
        if (sh[0]) t = (t >> 1) | (t & 32'h8000_0000);
        return t;
    endfunction

    function automatic logic [31:0] bus_ref(input logic [3:0] code);
        case (code)
            4'd0: return mdl[1];
            4'd1: return mdl[2];
            4'd2: return fb_m[7] ? (32'hFFFF_FF00 | 32'(fb_m)) : 32'(fb_m);
            4'd3: return 32'(fb_m);
            4'd4: return mdl[3];
            4'd5: return mdl[4];
            4'd6: return mdl[5];
            4'd7: return mdl[6];
            4'd8: return mdl[7];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [8:0] m, input logic [3:0] bs, input logic [5:0] op,
                        input logic [1:0] sh, input logic ld = 1'b0, input logic [7:0] by = 8'h00);
        logic [31:0] r, s;
        c_mask = m; b_sel = bs; alu_op = op; shift_op = sh; fetch_ld = ld; fetch_byte = by;
        r = alu_ref(op, mdl[8], bus_ref(bs));
        s = shf_ref(sh, r);
        for (int i = 0; i < 9; i++) if (m[i]) mdl[i] = s;
        if (ld) fb_m = by;
        @(posedge clk);
        @(negedge clk);
        c_mask = '0; fetch_ld = 1'b0;
    endtask

    task automatic peek(input logic [3:0] code, output logic [31:0] v);
        step(9'h001, code, OP_B, 2'b00);
        v = mar_o;
    endtask

    task automatic peek_h(output logic [31:0] v);
        step(9'h001, 4'hF, OP_A, 2'b00);
        v = mar_o;
    endtask

    task automatic set_h(input logic [31:0] val);
        step(9'h000, 4'h0, OP_ZERO, 2'b00, 1'b1, val[31:24]);
        step(9'h100, 4'd3, OP_B, 2'b10);
        step(9'h000, 4'h0, OP_ZERO, 2'b00, 1'b1, val[23:16]);
        step(9'h100, 4'd3, OP_ADD, 2'b10);
        step(9'h000, 4'h0, OP_ZERO, 2'b00, 1'b1, val[15:8]);
        step(9'h100, 4'd3, OP_ADD, 2'b10);
        step(9'h000, 4'h0, OP_ZERO, 2'b00, 1'b1, val[7:0]);
        step(9'h100, 4'd3, OP_ADD, 2'b00);
    endtask

    task automatic set_reg(input int idx, input logic [31:0] val);
        set_h(val);
        step(9'(1) << idx, 4'hF, OP_A, 2'b00);
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e, a, b, hold_mar, hold_pc, hold_mdr;
        logic [31:0] avals [0:5] = '{32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h1234_ABCD, 32'h7FFF_FFFF};
        logic [31:0] bvals [0:5] = '{32'h0, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0F0F_5A5A, 32'h0000_0001};
        logic [31:0] svals [0:5] = '{32'h1, 32'h0080_0000, 32'h8000_0000, 32'h8000_0001, 32'hDEAD_BEEF, 32'h0};
        rst_n = 1'b0; c_mask = '0; b_sel = '0; alu_op = '0; shift_op = '0;
        fetch_ld = 1'b0; fetch_byte = '0;
        for (int i = 0; i < 9; i++) mdl[i] = '0;
        fb_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 mar", mar_o, 32'd0);
        chk("R1 mdr", mdr_o, 32'd0);
        chk("R1 pc", pc_o, 32'd0);
        chk("R1 n", 32'(n_o), 32'd0);
        chk("R1 z", 32'(z_o), 32'd0);
        for (int c = 0; c < 9; c++) begin
            peek(4'(c), v);
            chk("R1 reg", v, 32'd0);
        end
        peek_h(v);
        chk("R1 h", v, 32'd0);

        // R2 / R4: load registers and sweep every B code
        for (int i = 1; i < 8; i++) set_reg(i, next_rand());
        for (int c = 0; c < 16; c++) begin
            e = bus_ref(4'(c));
            peek(4'(c), v);
            if (c >= 9) chk("R4 unused code", v, 32'd0);
            else if (c == 2 || c == 3) chk("R3 fetch code", v, e);
            else chk("R2 bsel code", v, e);
        end
        chk("R8 mdr port", mdr_o, mdl[1]);
        chk("R8 pc port", pc_o, mdl[2]);

        // R3: every fetch byte, both extensions
        for (int by = 0; by < 256; by++) begin
            step(9'h000, 4'h0, OP_ZERO, 2'b00, 1'b1, 8'(by));
            peek(4'd2, v);
            chk("R3 sign ext", v, by[7] ? (32'hFFFF_FF00 | by) : 32'(by));
            peek(4'd3, v);
            chk("R3 zero ext", v, 32'(by));
        end

        // R12: load and read in the same cycle sees the old byte
        step(9'h001, 4'd3, OP_B, 2'b00, 1'b1, 8'h5A);
        chk("R12 old byte", mar_o, 32'h0000_00FF);
        peek(4'd3, v);
        chk("R12 new byte", v, 32'h0000_005A);

        // R5 / R6 / R10 / R11: ALU sweep, A from H, B from SP
        for (int p = 0; p < 6; p++) begin
            a = avals[p]; b = bvals[p];
            set_reg(3, b);
            set_h(a);
            for (int k = 0; k < 16; k++) begin
                e = alu_ref(ops[k], a, b);
                step(9'h001, 4'd4, ops[k], 2'b00);
                if (ops[k][5:4] == 2'b11) chk("R6 adder op", mar_o, e);
                else chk("R5 logic op", mar_o, e);
                chk("R10 n flag", 32'(n_o), 32'(e[31]));
                chk("R11 z flag", 32'(z_o), 32'(e == 32'd0));
            end
        end

        // R7 / R10 / R11: shifter codes, flags from unshifted value
        for (int p = 0; p < 6; p++) begin
            set_reg(3, svals[p]);
            for (int s = 0; s < 4; s++) begin
                step(9'h001, 4'd4, OP_B, 2'(s));
                chk("R7 shift", mar_o, shf_ref(2'(s), svals[p]));
                chk("R10 n unshifted", 32'(n_o), 32'(svals[p][31]));
                chk("R11 z unshifted", 32'(z_o), 32'(svals[p] == 32'd0));
            end
        end

        // R8 / R9: TOS and PC together, others unchanged
        set_h(32'hCAFE_F00D);
        step(9'b001000100, 4'hF, OP_A, 2'b00);
        chk("R8 pc multi", pc_o, 32'hCAFE_F00D);
        peek(4'd7, v);
        chk("R8 tos multi", v, 32'hCAFE_F00D);
        peek(4'd0, v); chk("R9 mdr kept", v, mdl[1]);
        peek(4'd4, v); chk("R9 sp kept", v, mdl[3]);
        peek(4'd5, v); chk("R9 lv kept", v, mdl[4]);
        peek(4'd6, v); chk("R9 cpp kept", v, mdl[5]);
        peek(4'd8, v); chk("R9 opc kept", v, mdl[7]);

        // R8: all nine at once
        step(9'h1FF, 4'h0, OP_NEG1, 2'b00);
        chk("R8 mar all", mar_o, 32'hFFFF_FFFF);
        chk("R8 mdr all", mdr_o, 32'hFFFF_FFFF);
        chk("R8 pc all", pc_o, 32'hFFFF_FFFF);
        for (int c = 4; c < 9; c++) begin
            peek(4'(c), v);
            chk("R8 reg all", v, 32'hFFFF_FFFF);
        end
        peek_h(v);
        chk("R8 h all", v, 32'hFFFF_FFFF);

        // R9: empty mask holds every port-visible register
        hold_mar = mar_o; hold_pc = pc_o; hold_mdr = mdr_o;
        step(9'h000, 4'd4, OP_INCB, 2'b00);
        chk("R9 mar hold", mar_o, hold_mar);
        chk("R9 pc hold", pc_o, hold_pc);
        chk("R9 mdr hold", mdr_o, hold_mdr);
        peek(4'd4, v);
        chk("R9 sp hold", v, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule